// File: doc/BRIEF.md
# Seconds Alarm Comparator with Maskable Interrupts

This block compares a 48-bit alarm time against an external running seconds count. When the count reaches the alarm value, it latches a primary event flag. A second flag is latched from an alternate event input. Both flags stay set until software clears them. An enable bit for each flag decides whether it drives the level-high interrupt line.

Software reaches the block through a small word-addressed register port. Reads are combinational. Writes take effect on the next rising clock edge. The alarm value is split into a 32-bit low word and a 16-bit high word. The compare is held off from any write of the low word until the high word has also been written, so a match can never fire on a half-updated value.

Top module: `alarm_cmp`

## Requirements
- R1: After reset, every register reads 0 and `irq_o` is low. The alarm is not armed after reset.
- R2: Address 0 holds the low 32 alarm bits and address 1 holds the high 16 alarm bits. Both are read/write. Bits 31:16 of address 1 read as 0.
- R3: Raw status bit 0 sets on a clock edge where `sec_tick` is high, the alarm is armed, and `sec_cnt` equals the 48-bit alarm value. It sets on no other edge, and it stays set until cleared.
- R4: A write to address 0 disarms the compare. A later write to address 1 re-arms it.
- R5: A high `alt_evt` on a clock edge sets raw status bit 1.
- R6: Address 2 returns the raw status in bits 1:0, regardless of the enables. Address 3 returns the status ANDed with the enables.
- R7: Writing 1 to a bit at address 4 sets that enable. Writing 1 to a bit at address 5 clears it. Zero bits change nothing. Both addresses read back the enables in bits 1:0.
- R8: Writing 1 to a bit at address 2 or address 3 clears that status bit. Zero bits leave it unchanged.
- R9: If a status bit's set condition and a clear write occur on the same edge, the bit ends up set.
- R10: `irq_o` is high exactly while some status bit is set whose enable is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_cnt | input | 48 | Current seconds count |
| sec_tick | input | 1 | High for one cycle when `sec_cnt` has just taken a new value |
| alt_evt | input | 1 | Alternate event pulse, latched into status bit 1 |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| irq_o | output | 1 | Level-high interrupt |

## Verification
On every cycle, the assertions check four things:
- a qualified match always latches status bit 0, and bit 0 never rises without one;
- the alternate input always latches bit 1;
- a low-word write always disarms the compare;
- the enables move only on writes to their two addresses.

The bench scenarios cover the rest. It sweeps the alarm against a counter whose low word wraps, which exercises the full 48-bit compare. It checks that a tick-less equality and a half-written alarm do not fire. It walks all enable combinations through both status views and the interrupt line, and it shows that a set wins over a clear on the same edge.

// File: rtl/alarm_cmp.sv
module alarm_cmp #(
  parameter int LO_W  = 32,
  parameter int HI_W  = 16,
  parameter int DW    = 32,
  parameter int AW    = 3,
  parameter int CNT_W = LO_W + HI_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] sec_cnt,
  input  logic             sec_tick,
  input  logic             alt_evt,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic             irq_o
);
  localparam logic [AW-1:0] A_LO  = AW'(0);
  localparam logic [AW-1:0] A_HI  = AW'(1);
  localparam logic [AW-1:0] A_RAW = AW'(2);
  localparam logic [AW-1:0] A_MSK = AW'(3);
  localparam logic [AW-1:0] A_SET = AW'(4);
  localparam logic [AW-1:0] A_CLR = AW'(5);

  logic [LO_W-1:0] alm_lo;
  logic [HI_W-1:0] alm_hi;
  logic            armed;
  logic [1:0]      stat_q, en_q;

  wire we_lo  = bus_we && bus_addr == A_LO;
  wire we_hi  = bus_we && bus_addr == A_HI;
  wire we_w1c = bus_we && (bus_addr == A_RAW || bus_addr == A_MSK);
  wire we_set = bus_we && bus_addr == A_SET;
  wire we_clr = bus_we && bus_addr == A_CLR;

  wire       pri_hit = sec_tick && armed && (sec_cnt == {alm_hi, alm_lo});
  wire [1:0] clr_m   = we_w1c ? bus_wdata[1:0] : 2'b00;
  wire [1:0] masked  = stat_q & en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alm_lo <= '0;
      alm_hi <= '0;
      armed  <= 1'b0;
      stat_q <= 2'b00;
      en_q   <= 2'b00;
    end else begin
      if (we_lo) begin
        alm_lo <= bus_wdata[LO_W-1:0];
        armed  <= 1'b0;
      end
      if (we_hi) begin
        alm_hi <= bus_wdata[HI_W-1:0];
        armed  <= 1'b1;
      end
      stat_q <= (stat_q & ~clr_m) | {alt_evt, pri_hit};
      if (we_set) en_q <= en_q | bus_wdata[1:0];
      if (we_clr) en_q <= en_q & ~bus_wdata[1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_LO:         bus_rdata[LO_W-1:0] = alm_lo;
      A_HI:         bus_rdata[HI_W-1:0] = alm_hi;
      A_RAW:        bus_rdata[1:0]      = stat_q;
      A_MSK:        bus_rdata[1:0]      = masked;
      A_SET, A_CLR: bus_rdata[1:0]      = en_q;
      default:      bus_rdata           = '0;
    endcase
  end

  assign irq_o = |masked;

  a_r3_hit_latches: assert property (@(posedge clk) disable iff (!rst_n)
    pri_hit |=> stat_q[0]);
  a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!pri_hit && !stat_q[0]) |=> !stat_q[0]);
  a_r5_alt_latches: assert property (@(posedge clk) disable iff (!rst_n)
    alt_evt |=> stat_q[1]);
  a_r4_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    we_lo |=> !armed);
  a_r7_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_set || we_clr) |=> $stable(en_q));
endmodule

// File: tb/tb_alarm_cmp.sv
module tb_alarm_cmp;
  localparam int CLK_P = 10;
  localparam logic [47:0] BASE = 48'h00A5_FFFF_FFFC;

  logic        clk = 0, rst_n = 0;
  logic [47:0] sec = '0;
  logic        tick = 0, alt = 0, we = 0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq;
  int          nvec = 0, nbad = 0;

  alarm_cmp dut (.clk(clk), .rst_n(rst_n), .sec_cnt(sec), .sec_tick(tick),
    .alt_evt(alt), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rdata), .irq_o(irq));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic tk(input logic [47:0] v);
    @(negedge clk); sec = v; tick = 1;
    @(negedge clk); tick = 0;
  endtask

  initial begin
    #(CLK_P * 150000);
    nbad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [47:0] x, al;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d); chk("R1 reg", d, 0);
    end
    chk("R1 irq", {31'b0, irq}, 0);

    wr(0, 32'hDEADBEEF); wr(1, 32'hFFFF1234);
    rd(0, d); chk("R2 lo", d, 32'hDEADBEEF);
    rd(1, d); chk("R2 hi", d, 32'h0000_1234);

    for (int k = 0; k < 8; k++) begin
      al = BASE + 48'(k);
      wr(0, al[31:0]); wr(1, {16'h0, al[47:32]}); wr(2, 3);
      for (int s = 0; s < 8; s++) begin
        tk(BASE + 48'(s));
        rd(2, d); chk("R3 sweep", d, (s >= k) ? 1 : 0);
      end
    end

    al = BASE + 3;
    wr(0, al[31:0]); wr(1, {16'h0, al[47:32]}); wr(2, 3);
    @(negedge clk); sec = al; tick = 0;
    repeat (3) @(negedge clk);
    rd(2, d); chk("R3 no tick", d, 0);

    x = BASE + 100;
    wr(0, x[31:0]);
    tk(x); tk({al[47:32], x[31:0]});
    rd(2, d); chk("R4 disarmed", d, 0);
    wr(1, {16'h0, x[47:32]});
    tk(x);
    rd(2, d); chk("R4 rearmed", d, 1);

    wr(2, 3);
    @(negedge clk); alt = 1; @(negedge clk); alt = 0;
    rd(2, d); chk("R5 alt", d, 2);
    tk(x);
    rd(2, d); chk("R3 both", d, 3);

    for (int e = 0; e < 4; e++) begin
      wr(5, 3); wr(4, 32'(e));
      rd(4, d); chk("R7 set rd", d, 32'(e));
      rd(5, d); chk("R7 clr rd", d, 32'(e));
      rd(3, d); chk("R6 masked", d, 32'(e));
      rd(2, d); chk("R6 raw", d, 3);
      chk("R10 irq", {31'b0, irq}, (e != 0) ? 1 : 0);
    end
    wr(4, 0); rd(4, d); chk("R7 set zero", d, 3);
    wr(5, 0); rd(4, d); chk("R7 clr zero", d, 3);
    wr(5, 1); rd(4, d); chk("R7 clr bit", d, 2);

    wr(2, 0); rd(2, d); chk("R8 zero", d, 3);
    wr(3, 1); rd(2, d); chk("R8 clr0", d, 2);
    chk("R10 irq on", {31'b0, irq}, 1);
    wr(2, 2); rd(2, d); chk("R8 clr1", d, 0);
    chk("R10 irq off", {31'b0, irq}, 0);

    @(negedge clk); addr = 2; wdata = 2; we = 1; alt = 1;
    @(negedge clk); we = 0; alt = 0;
    rd(2, d); chk("R9 alt wins", d, 2);
    @(negedge clk); addr = 2; wdata = 1; we = 1; sec = x; tick = 1;
    @(negedge clk); we = 0; tick = 0;
    rd(2, d); chk("R9 pri wins", d, 3);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule